// File: doc/BRIEF.md
# Channel Response Collector

The collector moves response words from a set of child channels into an inbound mailbox queue. Each child presents a level-sensitive "word available" flag and its head word. The child drops the word when the collector strobes that channel's pop line. The collector writes each word into the queue through a push port and watches the queue's full and empty flags.

Work happens in drain passes. A pass starts after a bus access to the mailbox, or when any channel's available flag changes value. Triggers that arrive while a pass is running are held and start one more pass afterwards. A pass visits channels from index 0 upward. It stays on a channel, moving one word per clock, until that channel has nothing left. If the queue fills, the pass stops at once. When the pass ends, the data-pending flag and the interrupt line are recomputed from the queue's empty flag and the interrupt enable. They keep their values at all other times.

A channel that claims a word but presents the invalid marker has broken the protocol. The collector pops and discards that word, and raises a sticky error flag.

Top module: `resp_collector`

## Requirements
- R1: After reset, no pop or push strobe is active and data_pend_o, irq_o and proto_err_o are 0. The stored copy of the available flags is cleared, so channels already available on release start a pass.
- R2: Within a pass, every word from a lower-numbered channel is pushed before any word from a higher-numbered channel. Words from one channel keep the order the channel supplied them.
- R3: At most one word moves per cycle. A push occurs only in a cycle in which exactly one pop strobe is active, and mbox_data_o then equals that channel's presented word.
- R4: No push occurs while mbox_full_i is 1. A full queue ends the pass, and words not yet moved stay in their channels.
- R5: A one-cycle pulse on bus_access_i starts a pass. Without a trigger, no word moves, even after the queue gains space.
- R6: A change of any bit of chan_avail_i, rising or falling, starts a pass.
- R7: One cycle after a pass ends, data_pend_o equals NOT mbox_empty_i and irq_o equals data_pend_o AND irq_en_i. Both hold their values until the next pass ends.
- R8: A word equal to INVALID_WORD (default 32'hFFFF_FFFF) on an available channel is popped but not pushed, and it sets proto_err_o. proto_err_o stays 1 until reset.
- R9: Changing irq_en_i alone, with no pass, leaves irq_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_avail_i | input | N_CHAN | Per-channel word-available level |
| chan_data_i | input | N_CHAN*DATA_W | Head word of each channel, channel c at bits c*DATA_W upward |
| chan_pop_o | output | N_CHAN | Per-channel pop strobe |
| bus_access_i | input | 1 | One-cycle pulse per mailbox bus access |
| irq_en_i | input | 1 | Data-pending interrupt enable |
| mbox_full_i | input | 1 | Inbound queue full |
| mbox_empty_i | input | 1 | Inbound queue empty |
| mbox_push_o | output | 1 | Push strobe into the inbound queue |
| mbox_data_o | output | DATA_W | Word being pushed |
| data_pend_o | output | 1 | Queue held data at the end of the last pass |
| irq_o | output | 1 | Interrupt request |
| proto_err_o | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with its defaults: eight channels and 32-bit words. It sweeps all 256 availability patterns, and each pattern gives the channels a different depth. This exercises every ordering of empty and loaded channels, including the case where channel 7 ends a pass on the last index. A behavioural queue of depth 64 never fills during the sweep. Depths of 3 and 1 are then used to stop a pass partway through a channel. They also show that held words wait for a bus access or for a flag that falls.

// File: rtl/collector_pkg.sv
package collector_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_FINISH
  } scan_state_e;
endpackage

// File: rtl/collector_trigger.sv
module collector_trigger #(
  parameter int N_CHAN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CHAN-1:0] chan_avail_i,
  input  logic              bus_access_i,
  input  logic              busy_i,
  output logic              start_req_o
);
  logic [N_CHAN-1:0] avail_q;
  logic              held_q;
  logic              trig;

  assign trig        = bus_access_i || (chan_avail_i != avail_q);
  assign start_req_o = trig || held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avail_q <= '0;
      held_q  <= 1'b0;
    end else begin
      avail_q <= chan_avail_i;
      // idle consumes the request; triggers during a pass are held
      if (!busy_i)   held_q <= 1'b0;
      else if (trig) held_q <= 1'b1;
    end
  end

  p_held_only_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q |-> $past(busy_i));
endmodule

// File: rtl/collector_scan.sv
module collector_scan
  import collector_pkg::*;
#(
  parameter int N_CHAN = 8,
  parameter int IDX_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cur_avail_i,
  input  logic             mbox_full_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             move_o,
  output logic             finish_o
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(N_CHAN - 1);

  scan_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SCAN;
        idx_d   = '0;
      end
      ST_SCAN: begin
        if (mbox_full_i) begin
          state_d = ST_FINISH;
        end else if (!cur_avail_i) begin
          if (idx_q == LastIdx) state_d = ST_FINISH;
          else                  idx_d   = idx_q + 1'b1;
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign idx_o    = idx_q;
  assign move_o   = (state_q == ST_SCAN) && cur_avail_i && !mbox_full_i;
  assign finish_o = (state_q == ST_FINISH);

  p_ascending_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN) |=> (state_q != ST_SCAN) || (idx_q >= $past(idx_q)));
  p_full_ends_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && mbox_full_i) |=> (state_q == ST_FINISH));
endmodule

// File: rtl/collector_status.sv
module collector_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic finish_i,
  input  logic mbox_empty_i,
  input  logic irq_en_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (finish_i) begin
      pend_q <= !mbox_empty_i;
      irq_q  <= !mbox_empty_i && irq_en_i;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  p_irq_needs_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> pend_q);
  p_hold_between_passes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !finish_i |=> $stable(irq_q) && $stable(pend_q));
endmodule

// File: rtl/resp_collector.sv
module resp_collector #(
  parameter int          N_CHAN       = 8,
  parameter int          DATA_W       = 32,
  parameter logic [31:0] INVALID_WORD = 32'hFFFF_FFFF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_CHAN-1:0]        chan_avail_i,
  input  logic [N_CHAN*DATA_W-1:0] chan_data_i,
  output logic [N_CHAN-1:0]        chan_pop_o,
  input  logic                     bus_access_i,
  input  logic                     irq_en_i,
  input  logic                     mbox_full_i,
  input  logic                     mbox_empty_i,
  output logic                     mbox_push_o,
  output logic [DATA_W-1:0]        mbox_data_o,
  output logic                     data_pend_o,
  output logic                     irq_o,
  output logic                     proto_err_o
);
  localparam int IdxW = (N_CHAN > 1) ? $clog2(N_CHAN) : 1;
  localparam logic [DATA_W-1:0] BadWord = DATA_W'(INVALID_WORD);

  logic            start_req, busy, move, finish;
  logic [IdxW-1:0] idx;
  logic            cur_avail, word_bad;
  logic [DATA_W-1:0] cur_word;
  logic            err_q;

  collector_trigger #(.N_CHAN(N_CHAN)) i_trigger (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .chan_avail_i (chan_avail_i),
    .bus_access_i (bus_access_i),
    .busy_i       (busy),
    .start_req_o  (start_req)
  );

  collector_scan #(.N_CHAN(N_CHAN), .IDX_W(IdxW)) i_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_req),
    .cur_avail_i (cur_avail),
    .mbox_full_i (mbox_full_i),
    .busy_o      (busy),
    .idx_o       (idx),
    .move_o      (move),
    .finish_o    (finish)
  );

  collector_status i_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .finish_i     (finish),
    .mbox_empty_i (mbox_empty_i),
    .irq_en_i     (irq_en_i),
    .pend_o       (data_pend_o),
    .irq_o        (irq_o)
  );

  assign cur_avail = chan_avail_i[idx];
  assign cur_word  = chan_data_i[idx*DATA_W +: DATA_W];
  assign word_bad  = (cur_word == BadWord);

  for (genvar g = 0; g < N_CHAN; g++) begin : g_pop
    assign chan_pop_o[g] = move && (idx == IdxW'(g));
  end

  assign mbox_push_o = move && !word_bad;
  assign mbox_data_o = cur_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              err_q <= 1'b0;
    else if (move && word_bad) err_q <= 1'b1;
  end
  assign proto_err_o = err_q;

  p_single_pop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chan_pop_o));
  p_push_has_pop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbox_push_o |-> ($countones(chan_pop_o) == 1));
  p_no_push_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbox_push_o |-> !mbox_full_i);
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);
endmodule

// File: tb/test_resp_collector.sv
module test_resp_collector;
  localparam int N = 8;
  localparam int W = 32;
  localparam logic [31:0] BAD = 32'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] avail, pop;
  logic [N*W-1:0] cdata;
  logic bus_acc = 1'b0, irq_en = 1'b0;
  logic mb_full, mb_empty, push, pend, irq, perr;
  logic [W-1:0] pdata;

  logic [31:0] ch_mem [N][4];
  int ch_rd [N];
  int ch_cnt [N];
  logic [31:0] mb_mem [64];
  int mb_wr = 0, mb_rd = 0, mb_depth = 64;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  resp_collector i_resp_collector (
    .clk_i(clk), .rst_ni(rst_n), .chan_avail_i(avail), .chan_data_i(cdata),
    .chan_pop_o(pop), .bus_access_i(bus_acc), .irq_en_i(irq_en),
    .mbox_full_i(mb_full), .mbox_empty_i(mb_empty), .mbox_push_o(push),
    .mbox_data_o(pdata), .data_pend_o(pend), .irq_o(irq), .proto_err_o(perr)
  );

  always_comb begin
    for (int i = 0; i < N; i++) begin
      avail[i] = ch_rd[i] < ch_cnt[i];
      cdata[i*W +: W] = (ch_rd[i] < 4) ? ch_mem[i][ch_rd[i]] : '0;
    end
    mb_full  = (mb_wr - mb_rd) >= mb_depth;
    mb_empty = (mb_wr == mb_rd);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] wd(input int ch, input int k);
    return 32'hA000_0000 | (ch << 8) | k;
  endfunction

  // behavioural children and queue, updated from pre-edge strobes
  always @(posedge clk) begin
    if (rst_n) begin
      if (push) begin
        chk(!mb_full, "R4 push while full", {31'd0, mb_full}, 32'd0);
        chk($countones(pop) == 1, "R3 pops with push", 32'($countones(pop)), 32'd1);
        mb_mem[mb_wr % 64] <= pdata;
        mb_wr <= mb_wr + 1;
      end
      for (int i = 0; i < N; i++) begin
        if (pop[i]) begin
          if (push) chk(pdata == ch_mem[i][ch_rd[i] % 4], "R3 pushed word", pdata, ch_mem[i][ch_rd[i] % 4]);
          ch_rd[i] <= ch_rd[i] + 1;
        end
      end
    end
  end

  task automatic pulse_bus();
    @(negedge clk) bus_acc = 1'b1;
    @(negedge clk) bus_acc = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    for (int c = 0; c < N; c++) begin
      ch_rd[c] <= 0;
      ch_cnt[c] <= 0;
    end
    mb_wr <= 0;
    mb_rd <= 0;
    #1;
  endtask

  initial begin
    for (int c = 0; c < N; c++) begin
      ch_rd[c] = 0;
      ch_cnt[c] = 0;
      for (int k = 0; k < 4; k++) ch_mem[c][k] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pop == '0 && !push, "R1 strobes", {pop, 7'd0, push}, 32'd0);
    chk({pend, irq, perr} == 3'b000, "R1 flags", {29'd0, pend, irq, perr}, 32'd0);
    rst_n = 1'b1;
    idle(4);

    // sweep all availability patterns, queue never full
    for (int m = 0; m < 256; m++) begin
      int tot;
      bit en;
      tot = 0;
      en = (m % 3) != 0;
      @(negedge clk);
      irq_en = en;
      for (int c = 0; c < N; c++) begin
        int cnt;
        cnt = m[c] ? 1 + ((c + m) % 3) : 0;
        for (int k = 0; k < 4; k++) ch_mem[c][k] <= wd(c, k);
        ch_rd[c] <= 0;
        ch_cnt[c] <= cnt;
        tot += cnt;
      end
      idle(80);
      chk(mb_wr == tot, "R2 word count", 32'(mb_wr), 32'(tot));
      begin
        int p;
        p = 0;
        for (int c = 0; c < N; c++)
          for (int k = 0; k < (m[c] ? 1 + ((c + m) % 3) : 0); k++) begin
            chk(mb_mem[p] == wd(c, k), "R2 order", mb_mem[p], wd(c, k));
            p++;
          end
      end
      chk(pend == (tot > 0), "R7 pending", {31'd0, pend}, {31'd0, tot > 0});
      chk(irq == (tot > 0 && en), "R7 irq", {31'd0, irq}, {31'd0, tot > 0 && en});
      mb_rd <= mb_wr;
      idle(3);
      chk(pend == (tot > 0), "R7 hold until pass", {31'd0, pend}, {31'd0, tot > 0});
      pulse_bus();
      idle(20);
      chk(!pend && !irq, "R5 R7 refresh after bus access", {30'd0, pend, irq}, 32'd0);
      mb_wr <= 0;
      mb_rd <= 0;
    end

    // R4 full queue stops the pass
    clear_all();
    mb_depth = 3;
    irq_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      ch_mem[1][k] <= wd(1, k);
      ch_mem[4][k] <= wd(4, k);
    end
    ch_cnt[1] <= 2;
    ch_cnt[4] <= 3;
    idle(80);
    chk(mb_wr == 3, "R4 stop at full", 32'(mb_wr), 32'd3);
    chk(mb_mem[2] == wd(4, 0), "R4 last word", mb_mem[2], wd(4, 0));
    chk(ch_rd[4] == 1, "R4 words left in channel", 32'(ch_rd[4]), 32'd1);
    chk(pend && irq, "R7 irq with data", {30'd0, pend, irq}, 32'd3);
    mb_rd <= 3;
    idle(10);
    chk(mb_wr == 3, "R5 no move without trigger", 32'(mb_wr), 32'd3);
    pulse_bus();
    idle(80);
    chk(mb_wr == 5, "R5 bus access resumes", 32'(mb_wr), 32'd5);
    chk(mb_mem[3] == wd(4, 1) && mb_mem[4] == wd(4, 2), "R5 resumed order", mb_mem[4], wd(4, 2));

    // R6 falling flag triggers a pass
    clear_all();
    mb_depth = 1;
    ch_cnt[0] <= 2;
    ch_cnt[3] <= 1;
    for (int k = 0; k < 4; k++) begin
      ch_mem[0][k] <= wd(0, k);
      ch_mem[3][k] <= wd(3, k);
    end
    idle(80);
    chk(mb_wr == 1 && mb_mem[0] == wd(0, 0), "R4 depth one", mb_mem[0], wd(0, 0));
    mb_rd <= 1;
    idle(10);
    chk(mb_wr == 1, "R5 idle with space", 32'(mb_wr), 32'd1);
    @(negedge clk);
    ch_cnt[0] <= ch_rd[0];
    idle(40);
    chk(mb_wr == 2 && mb_mem[1] == wd(3, 0), "R6 falling flag pass", mb_mem[1], wd(3, 0));

    // R8 invalid marker
    clear_all();
    mb_depth = 64;
    chk(!perr, "R8 clear before", {31'd0, perr}, 32'd0);
    ch_mem[2][0] <= BAD;
    ch_mem[2][1] <= 32'h55;
    ch_mem[5][0] <= 32'h77;
    ch_cnt[2] <= 2;
    ch_cnt[5] <= 1;
    idle(60);
    chk(mb_wr == 2, "R8 bad word dropped", 32'(mb_wr), 32'd2);
    chk(mb_mem[0] == 32'h55 && mb_mem[1] == 32'h77, "R8 good words", mb_mem[0], 32'h55);
    chk(ch_rd[2] == 2, "R8 bad word popped", 32'(ch_rd[2]), 32'd2);
    chk(perr, "R8 error set", {31'd0, perr}, 32'd1);
    pulse_bus();
    idle(20);
    chk(perr, "R8 error sticky", {31'd0, perr}, 32'd1);

    // R9 enable alone has no effect
    clear_all();
    irq_en = 1'b0;
    ch_mem[0][0] <= 32'h99;
    ch_cnt[0] <= 1;
    idle(30);
    chk(pend && !irq, "R7 masked", {30'd0, pend, irq}, 32'd2);
    irq_en = 1'b1;
    idle(10);
    chk(!irq, "R9 enable without pass", {31'd0, irq}, 32'd0);
    pulse_bus();
    idle(20);
    chk(irq, "R7 enable after pass", {31'd0, irq}, 32'd1);
    irq_en = 1'b0;
    idle(10);
    chk(irq, "R9 disable without pass", {31'd0, irq}, 32'd1);

    // R1 R8 reset clears error
    rst_n = 1'b0;
    idle(2);
    chk(!perr && !pend && !irq, "R1 R8 reset clears", {29'd0, perr, pend, irq}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule